// File: doc/BRIEF.md
# Control Register File with Timer and Host Mailbox

This block holds a processor core's control registers behind one addressed port. Software selects a register with a 5-bit address and then reads it or writes it. Many registers have side effects when they are accessed.

- Writing the timer compare value drops the timer interrupt.
- The outbound mailbox takes only the first nonzero value.
- A write to the inbound mailbox raises or drops the host interrupt.
- A status write leaves the hardware-owned pending bits unchanged.
- Flushing the translation cache and sending a message to another core are outside this block. Each of them appears only as a one-cycle pulse output.

A single counter serves four alias addresses. It advances once per retired instruction. It sets the timer interrupt when it steps from one below the compare value up to the compare value. The pending field of the status word is driven onto its own output for the core's interrupt logic.

The outbound mailbox is a two-state machine:
- **BOX_EMPTY**: the register holds zero. A nonzero write loads the value and takes the transition *load* to BOX_FULL. A zero write stays in BOX_EMPTY.
- **BOX_FULL**: every write is ignored. Only reset returns the machine to BOX_EMPTY.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset the status reads 0x0000_0001 (supervisor bit 0 set, wide-mode bits clear). The counter, compare value, pending bits, both mailboxes and the scratch registers read zero, and both pulse outputs are low.
- R2: The flags register (0x00) keeps 5 bits and the rounding register (0x01) keeps 3 bits. The combined view (0x02) reads rounding in bits [7:4+1] and flags in bits [4:0], with the upper bits zero. A write to 0x02 loads both fields from those same positions.
- R3: A write to status (0x03) replaces bits [23:0] but leaves the pending field [31:24] unchanged. It forces bits [15:7] to zero. It forces bits 6:5 to zero when wide mode is absent, and bit 4 to zero when no FPU is present.
- R4: flush_req is high for exactly one cycle after a status write or a read of address 0x13. A read of 0x13 returns zero.
- R5: Addresses 0x06, 0x07, 0x08 and 0x09 all read and write the same counter.
- R6: The counter adds one on each cycle in which retire is high. A counter write in the same cycle wins, and the increment is lost.
- R7: Pending bit 7 (status bit 31) is set when an increment moves the counter from compare-1 to compare. A write to compare (0x0A) clears it, and that clear takes priority.
- R8: The outbound mailbox (0x0F) accepts a write only while it holds zero.
- R9: A write to the inbound mailbox (0x10) stores the value. It sets pending bit 6 when the value is nonzero and clears it when the value is zero.
- R10: The page-table base (0x0B) stores write data with its low PAGE_OFS_W bits cleared. The address-space ID (0x11) reads 0, the implementation ID (0x12) reads 1, and the hart number (0x0E) reads HART_NUM.
- R11: Unmapped addresses (0x16 to 0x1F) and the write-only addresses 0x14 and 0x15 read all ones.
- R12: A write to 0x15 sets pending bit 5 to write-data bit 0. A write to 0x14 raises msg_send for exactly one cycle.
- R13: EPC (0x04), trap vector (0x05) and the two scratch registers (0x0C, 0x0D) store and return full 32-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr, combinational |
| retire | input | 1 | One instruction retired this cycle |
| pend_out | output | 8 | Interrupt-pending field (status bits 31:24) |
| flush_req | output | 1 | One-cycle translation-flush request |
| msg_send | output | 1 | One-cycle inter-core message request |

## Verification
Read data is combinational, so the bench samples it 1 ns after it places an address, within that same cycle. A write takes effect at the next rising edge. The bench drives each write on a falling edge and reads the result back no earlier than the falling edge that follows. Timer and host pending bits, and both pulse outputs, are registered once and show up one edge after their cause. The bench checks each pulse at the falling edge right after the triggering access, and confirms it has dropped one cycle later. Counter-crossing checks single-step retire one cycle at a time, so the cycle in which the timer sets is known exactly.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int FLAGS_W   = 5;
    localparam int ROUND_W   = 3;
    localparam int PEND_W    = 8;
    localparam int STAT_LO_W = DATA_W - PEND_W;

    // status bit positions
    localparam int ST_SUP    = 0;
    localparam int ST_UWIDE  = 5;
    localparam int ST_SWIDE  = 6;
    localparam int ST_FPU    = 4;
    localparam int ST_RSV_LO = 7;
    localparam int ST_RSV_HI = 15;

    // pending bit indices
    localparam int PI_MSG    = 5;
    localparam int PI_HOST   = 6;
    localparam int PI_TIMER  = 7;

    localparam logic [ADDR_W-1:0] A_FLAGS   = 5'h00;
    localparam logic [ADDR_W-1:0] A_ROUND   = 5'h01;
    localparam logic [ADDR_W-1:0] A_FPCTL   = 5'h02;
    localparam logic [ADDR_W-1:0] A_STATUS  = 5'h03;
    localparam logic [ADDR_W-1:0] A_EPC     = 5'h04;
    localparam logic [ADDR_W-1:0] A_VECTOR  = 5'h05;
    localparam logic [ADDR_W-1:0] A_CYCLE   = 5'h06;
    localparam logic [ADDR_W-1:0] A_TIME    = 5'h07;
    localparam logic [ADDR_W-1:0] A_RETIRED = 5'h08;
    localparam logic [ADDR_W-1:0] A_COUNT   = 5'h09;
    localparam logic [ADDR_W-1:0] A_COMPARE = 5'h0A;
    localparam logic [ADDR_W-1:0] A_PTBASE  = 5'h0B;
    localparam logic [ADDR_W-1:0] A_SCR0    = 5'h0C;
    localparam logic [ADDR_W-1:0] A_SCR1    = 5'h0D;
    localparam logic [ADDR_W-1:0] A_HARTNUM = 5'h0E;
    localparam logic [ADDR_W-1:0] A_TOHOST  = 5'h0F;
    localparam logic [ADDR_W-1:0] A_FRMHOST = 5'h10;
    localparam logic [ADDR_W-1:0] A_ASID    = 5'h11;
    localparam logic [ADDR_W-1:0] A_IMPLID  = 5'h12;
    localparam logic [ADDR_W-1:0] A_FLUSH   = 5'h13;
    localparam logic [ADDR_W-1:0] A_SENDMSG = 5'h14;
    localparam logic [ADDR_W-1:0] A_CLRMSG  = 5'h15;

    typedef enum logic {
        BOX_EMPTY = 1'b0,
        BOX_FULL  = 1'b1
    } box_state_e;
endpackage

// File: rtl/ctlreg_timer.sv
module ctlreg_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         retire,
    input  logic         cnt_we,
    input  logic         cmp_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] compare,
    output logic         hit
);
    localparam logic [W:0] ONE = (W+1)'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            compare <= '0;
        end else begin
            if (cnt_we)      count <= wdata;
            else if (retire) count <= count + W'(1);
            if (cmp_we)      compare <= wdata;
        end
    end

    // crossing from below compare to at-or-above compare by a single step
    assign hit = retire && !cnt_we && (({1'b0, count} + ONE) == {1'b0, compare});
endmodule

// File: rtl/ctlreg_mailbox.sv
module ctlreg_mailbox
    import ctlreg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         to_we,
    input  logic         from_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] to_val,
    output logic [W-1:0] from_val,
    output logic         host_upd,
    output logic         host_lvl
);
    box_state_e state_q, state_d;
    logic       to_load;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BOX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BOX_EMPTY: if (to_we && (wdata != '0)) state_d = BOX_FULL;
            BOX_FULL:  state_d = BOX_FULL;
        endcase
    end

    always_comb begin
        to_load  = 1'b0;
        unique case (state_q)
            BOX_EMPTY: to_load = to_we;
            BOX_FULL:  to_load = 1'b0;
        endcase
        host_upd = from_we;
        host_lvl = (wdata != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_val   <= '0;
            from_val <= '0;
        end else begin
            if (to_load) to_val   <= wdata;
            if (from_we) from_val <= wdata;
        end
    end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import ctlreg_pkg::*;
#(
    parameter int HART_NUM     = 0,
    parameter int PAGE_OFS_W   = 12,
    parameter bit FPU_PRESENT  = 1'b1,
    parameter bit WIDE_PRESENT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              retire,
    output logic [PEND_W-1:0] pend_out,
    output logic              flush_req,
    output logic              msg_send
);
    localparam logic [DATA_W-1:0]    PTB_KEEP = {DATA_W{1'b1}} << PAGE_OFS_W;
    localparam logic [STAT_LO_W-1:0] STAT_RST =
        (STAT_LO_W'(1) << ST_SUP) | (WIDE_PRESENT ? (STAT_LO_W'(1) << ST_SWIDE) : '0);

    logic                 we, re;
    logic [FLAGS_W-1:0]   flags_q;
    logic [ROUND_W-1:0]   round_q;
    logic [STAT_LO_W-1:0] stat_lo_q, stat_wr_val;
    logic [PEND_W-1:0]    pend_q, pend_d;
    logic [DATA_W-1:0]    epc_q, vec_q, ptb_q, scr0_q, scr1_q;
    logic [DATA_W-1:0]    count_q, compare_q, tohost_q, fromhost_q;
    logic                 tmr_hit, host_upd, host_lvl;
    logic                 flush_q, send_q;

    assign we = acc_en &  acc_wr;
    assign re = acc_en & ~acc_wr;

    ctlreg_timer #(.W(DATA_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .retire  (retire),
        .cnt_we  (we && (acc_addr inside {A_CYCLE, A_TIME, A_RETIRED, A_COUNT})),
        .cmp_we  (we && (acc_addr == A_COMPARE)),
        .wdata   (acc_wdata),
        .count   (count_q),
        .compare (compare_q),
        .hit     (tmr_hit)
    );

    ctlreg_mailbox #(.W(DATA_W)) u_mbox (
        .clk      (clk),
        .rst_n    (rst_n),
        .to_we    (we && (acc_addr == A_TOHOST)),
        .from_we  (we && (acc_addr == A_FRMHOST)),
        .wdata    (acc_wdata),
        .to_val   (tohost_q),
        .from_val (fromhost_q),
        .host_upd (host_upd),
        .host_lvl (host_lvl)
    );

    // sanitise a status write
    always_comb begin
        stat_wr_val = acc_wdata[STAT_LO_W-1:0];
        stat_wr_val[ST_RSV_HI:ST_RSV_LO] = '0;
        if (!WIDE_PRESENT) begin
            stat_wr_val[ST_UWIDE] = 1'b0;
            stat_wr_val[ST_SWIDE] = 1'b0;
        end
        if (!FPU_PRESENT) stat_wr_val[ST_FPU] = 1'b0;
    end

    // pending field: hardware-owned
    always_comb begin
        pend_d = pend_q;
        if (tmr_hit) pend_d[PI_TIMER] = 1'b1;
        if (we && acc_addr == A_COMPARE) pend_d[PI_TIMER] = 1'b0;
        if (host_upd) pend_d[PI_HOST] = host_lvl;
        if (we && acc_addr == A_CLRMSG) pend_d[PI_MSG] = acc_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q   <= '0;
            round_q   <= '0;
            stat_lo_q <= STAT_RST;
            pend_q    <= '0;
            epc_q     <= '0;
            vec_q     <= '0;
            ptb_q     <= '0;
            scr0_q    <= '0;
            scr1_q    <= '0;
            flush_q   <= 1'b0;
            send_q    <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            flush_q <= (we && acc_addr == A_STATUS) || (re && acc_addr == A_FLUSH);
            send_q  <= we && acc_addr == A_SENDMSG;
            if (we) begin
                case (acc_addr)
                    A_FLAGS:  flags_q <= acc_wdata[FLAGS_W-1:0];
                    A_ROUND:  round_q <= acc_wdata[ROUND_W-1:0];
                    A_FPCTL: begin
                        flags_q <= acc_wdata[FLAGS_W-1:0];
                        round_q <= acc_wdata[FLAGS_W +: ROUND_W];
                    end
                    A_STATUS: stat_lo_q <= stat_wr_val;
                    A_EPC:    epc_q     <= acc_wdata;
                    A_VECTOR: vec_q     <= acc_wdata;
                    A_PTBASE: ptb_q     <= acc_wdata & PTB_KEEP;
                    A_SCR0:   scr0_q    <= acc_wdata;
                    A_SCR1:   scr1_q    <= acc_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (acc_addr)
            A_FLAGS:   acc_rdata = DATA_W'(flags_q);
            A_ROUND:   acc_rdata = DATA_W'(round_q);
            A_FPCTL:   acc_rdata = DATA_W'({round_q, flags_q});
            A_STATUS:  acc_rdata = {pend_q, stat_lo_q};
            A_EPC:     acc_rdata = epc_q;
            A_VECTOR:  acc_rdata = vec_q;
            A_CYCLE, A_TIME, A_RETIRED, A_COUNT:
                       acc_rdata = count_q;
            A_COMPARE: acc_rdata = compare_q;
            A_PTBASE:  acc_rdata = ptb_q;
            A_SCR0:    acc_rdata = scr0_q;
            A_SCR1:    acc_rdata = scr1_q;
            A_HARTNUM: acc_rdata = DATA_W'(HART_NUM);
            A_TOHOST:  acc_rdata = tohost_q;
            A_FRMHOST: acc_rdata = fromhost_q;
            A_ASID:    acc_rdata = '0;
            A_IMPLID:  acc_rdata = DATA_W'(1);
            A_FLUSH:   acc_rdata = '0;
            default:   acc_rdata = '1;
        endcase
    end

    assign pend_out  = pend_q;
    assign flush_req = flush_q;
    assign msg_send  = send_q;
endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk
    import ctlreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              retire,
    input logic [PEND_W-1:0] pend_out,
    input logic              flush_req,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] tohost_q
);
    logic wr_stat, wr_cmp, wr_cnt, wr_host;
    assign wr_stat = acc_en && acc_wr && acc_addr == A_STATUS;
    assign wr_cmp  = acc_en && acc_wr && acc_addr == A_COMPARE;
    assign wr_cnt  = acc_en && acc_wr && (acc_addr inside {A_CYCLE, A_TIME, A_RETIRED, A_COUNT});
    assign wr_host = acc_en && acc_wr && acc_addr == A_FRMHOST;

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !retire) |=> (pend_out == $past(pend_out))); // R3
    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> flush_req); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !wr_cnt) |=> (count_q == $past(count_q) + 32'd1)); // R6
    AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp |=> !pend_out[PI_TIMER]); // R7
    AST_TOHOST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tohost_q != '0) |=> $stable(tohost_q)); // R8
    AST_HOST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_host |=> (pend_out[PI_HOST] == ($past(acc_wdata) != '0))); // R9
endmodule

bind ctlreg_bank ctlreg_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .retire    (retire),
    .pend_out  (pend_out),
    .flush_req (flush_req),
    .count_q   (count_q),
    .tohost_q  (tohost_q)
);

// File: tb/sim_ctlreg_bank.sv
`timescale 1ns/1ps
module sim_ctlreg_bank;
    localparam logic [4:0] FLG = 5'h00, RND = 5'h01, FPC = 5'h02, STA = 5'h03,
                           EPC = 5'h04, VEC = 5'h05, CYC = 5'h06, TIM = 5'h07,
                           RET = 5'h08, CNT = 5'h09, CMP = 5'h0A, PTB = 5'h0B,
                           SC0 = 5'h0C, SC1 = 5'h0D, HRT = 5'h0E, TOH = 5'h0F,
                           FRH = 5'h10, ASI = 5'h11, IMP = 5'h12, FLU = 5'h13,
                           SND = 5'h14, CLM = 5'h15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, retire = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [7:0]  pend_out;
    logic        flush_req, msg_send;
    int          total = 0, fails = 0;

    always #10 clk = ~clk;

    ctlreg_bank #(.HART_NUM(3)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .retire(retire), .pend_out(pend_out), .flush_req(flush_req),
        .msg_send(msg_send)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rdc(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        #1 v = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0;
        chk(tag, v, exp);
    endtask

    task automatic step();
        @(negedge clk); retire = 1'b1;
        @(negedge clk); retire = 1'b0;
    endtask

    task automatic t_reset();
        rdc("R1 status", STA, 32'h0000_0001);
        rdc("R1 count", CNT, 32'h0);
        rdc("R1 compare", CMP, 32'h0);
        rdc("R1 tohost", TOH, 32'h0);
        rdc("R1 scratch", SC0, 32'h0);
        chk("R1 pending", {24'h0, pend_out}, 32'h0);
        chk("R1 pulses", {30'h0, flush_req, msg_send}, 32'h0);
    endtask

    task automatic t_fp();
        wr(FPC, 32'hFFFF_FFB5);
        rdc("R2 combined", FPC, 32'h0000_00B5);
        rdc("R2 flags", FLG, 32'h15);
        rdc("R2 round", RND, 32'h5);
        wr(FLG, 32'hFFFF_FFE3);
        rdc("R2 flags only", FPC, 32'h0000_00A3);
        wr(RND, 32'hFFFF_FFFA);
        rdc("R2 round only", FPC, 32'h0000_0043);
    endtask

    task automatic t_status();
        wr(FRH, 32'h1);
        wr(STA, 32'hFFFF_FFFF);
        chk("R4 flush after status write", {31'h0, flush_req}, 32'h1);
        @(negedge clk);
        chk("R4 flush one cycle", {31'h0, flush_req}, 32'h0);
        rdc("R3 status sanitised", STA, 32'h40FF_001F);
        chk("R3 pending kept", {24'h0, pend_out}, 32'h40);
        wr(STA, 32'h0000_0000);
        rdc("R3 pending kept on zero write", STA, 32'h4000_0000);
        wr(FRH, 32'h0);
        rdc("R4 flush addr reads zero", FLU, 32'h0);
        chk("R4 flush after read", {31'h0, flush_req}, 32'h1);
    endtask

    task automatic t_counter();
        wr(CYC, 32'd100);
        rdc("R5 time alias", TIM, 32'd100);
        rdc("R5 retired alias", RET, 32'd100);
        rdc("R5 count alias", CNT, 32'd100);
        wr(CNT, 32'd7);
        rdc("R5 cycle alias", CYC, 32'd7);
        for (int i = 0; i < 3; i++) step();
        rdc("R6 increments", CNT, 32'd10);
        @(negedge clk);
        retire = 1'b1; acc_en = 1'b1; acc_wr = 1'b1; acc_addr = CNT; acc_wdata = 32'd50;
        @(negedge clk);
        retire = 1'b0; acc_en = 1'b0; acc_wr = 1'b0;
        rdc("R6 write wins", CNT, 32'd50);
    endtask

    task automatic t_timer();
        wr(CMP, 32'd20);
        wr(CNT, 32'd18);
        step();
        chk("R7 below compare", {31'h0, pend_out[7]}, 32'h0);
        step();
        chk("R7 reaches compare", {31'h0, pend_out[7]}, 32'h1);
        step();
        chk("R7 stays set", {31'h0, pend_out[7]}, 32'h1);
        wr(CMP, 32'd30);
        chk("R7 compare write clears", {31'h0, pend_out[7]}, 32'h0);
        wr(CNT, 32'd30);
        chk("R7 software write no set", {31'h0, pend_out[7]}, 32'h0);
        wr(CNT, 32'd29);
        step();
        rdc("R7 status bit31", STA, 32'h8000_0000);
        wr(CMP, 32'd0);
        chk("R7 cleared again", {31'h0, pend_out[7]}, 32'h0);
    endtask

    task automatic t_mailbox();
        wr(TOH, 32'h0);
        rdc("R8 zero write", TOH, 32'h0);
        wr(TOH, 32'h1234);
        rdc("R8 first load", TOH, 32'h1234);
        wr(TOH, 32'h5678);
        rdc("R8 ignored while full", TOH, 32'h1234);
        wr(FRH, 32'hABCD);
        rdc("R9 stores", FRH, 32'hABCD);
        chk("R9 host set", {31'h0, pend_out[6]}, 32'h1);
        wr(FRH, 32'h0);
        rdc("R9 stores zero", FRH, 32'h0);
        chk("R9 host clear", {31'h0, pend_out[6]}, 32'h0);
    endtask

    task automatic t_ids();
        wr(PTB, 32'h1234_5FFF);
        rdc("R10 ptbase masked", PTB, 32'h1234_5000);
        rdc("R10 asid", ASI, 32'h0);
        rdc("R10 impl", IMP, 32'h1);
        rdc("R10 hart", HRT, 32'h3);
        rdc("R11 unmapped", 5'h1F, 32'hFFFF_FFFF);
        rdc("R11 unmapped low", 5'h16, 32'hFFFF_FFFF);
        rdc("R11 send reads ones", SND, 32'hFFFF_FFFF);
        rdc("R11 clear reads ones", CLM, 32'hFFFF_FFFF);
    endtask

    task automatic t_msg();
        wr(CLM, 32'h1);
        chk("R12 msg set", {31'h0, pend_out[5]}, 32'h1);
        wr(CLM, 32'hFFFF_FFFE);
        chk("R12 msg clear", {31'h0, pend_out[5]}, 32'h0);
        wr(SND, 32'h7);
        chk("R12 send pulse", {31'h0, msg_send}, 32'h1);
        @(negedge clk);
        chk("R12 send one cycle", {31'h0, msg_send}, 32'h0);
    endtask

    task automatic t_plain();
        wr(EPC, 32'hDEAD_BEEF);
        wr(VEC, 32'h8000_0100);
        wr(SC0, 32'h0F0F_F0F0);
        wr(SC1, 32'hA5A5_5A5A);
        rdc("R13 epc", EPC, 32'hDEAD_BEEF);
        rdc("R13 vector", VEC, 32'h8000_0100);
        rdc("R13 scratch0", SC0, 32'h0F0F_F0F0);
        rdc("R13 scratch1", SC1, 32'hA5A5_5A5A);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fp();
        t_status();
        t_counter();
        t_timer();
        t_mailbox();
        t_ids();
        t_msg();
        t_plain();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule